// File: doc/BRIEF.md
# Audio Silence Mute Flag Generator

This block watches the two decoded audio sample streams of a stereo converter and drives a single flag. An external analog mute switch uses that flag to silence the line outputs. The host logic pulses a strobe once per sample period. With each strobe it presents the current left and right sample words, the 4-bit output routing selection, and the two per-channel gain counters. The block samples its inputs only on those strobes.

A strobe is *qualifying* when either of two conditions holds. The first is that the audio that would actually reach the outputs is silent: both inputs are zero, or every input channel the routing uses is zero, or the routing silences both outputs. The second is that both gain counters have run down to zero. A saturating silence counter measures runs of consecutive qualifying strobes. The flag rises once a run reaches 2^SIL_LOG2 strobes. Any non-qualifying strobe clears the run and drops the flag at once. After reset the flag is forced high for an initialization window of INIT_STROBES strobes. Silence timing starts only after that window ends.

Top module: `zdm_mute_flag`

## Requirements
- R1: While reset is asserted, and after release until the INIT_STROBES-th strobe (9 by default), mute_o is 1. It becomes 0 in the cycle after that strobe, whatever the inputs were.
- R2: route_i bits [3:2] select the source of the left output and bits [1:0] select the source of the right output. Each code means: 00 = silenced, 01 = right input, 10 = left input, 11 = mean of both inputs. A channel is used when some output selects it directly or through the mean.
- R3: A strobe with both sample words equal to zero qualifies.
- R4: A strobe qualifies when every input channel used by the routing is zero, even if an unused channel carries non-zero data.
- R5: A strobe whose routing silences both outputs (route_i = 4'b0000) qualifies, whatever the sample data.
- R6: A strobe with both gain counters equal to zero qualifies. A zero counter on one channel alone does not.
- R7: After the initialization window, mute_o rises in the cycle after the 2^SIL_LOG2-th consecutive qualifying strobe, and not earlier.
- R8: A non-qualifying strobe after the window sets mute_o to 0 in the next cycle and restarts the run from zero.
- R9: The silence counter saturates at its terminal count, so mute_o stays 1 for any number of further qualifying strobes.
- R10: Inputs are sampled only on strobe cycles. mute_o changes only in the cycle after a strobe, and input changes between strobes have no effect.
- R11: Strobes inside the initialization window do not count toward the silence run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | One-cycle pulse per sample period |
| left_i | input | DATA_W | Left sample word |
| right_i | input | DATA_W | Right sample word |
| route_i | input | 4 | Output routing selection (see R2) |
| gain_l_i | input | GAIN_W | Left gain counter value |
| gain_r_i | input | GAIN_W | Right gain counter value |
| mute_o | output | 1 | Mute flag for the analog switch |

## Verification
The bench targets the edges of the silence window. It checks that the flag stays low on the strobe just before the terminal count and rises exactly on that count. A design off by one would assert early or late there. It runs well past twice the terminal count, which exposes a counter that wraps instead of saturating by letting the flag fall back. It places a non-zero sample on a channel that the routing does not use. A design that checks only raw input data would then never assert. It also uses routings that send the mean of both inputs, which a design that ignores the second source would wrongly qualify. A reset in mid-run with silent input catches designs that let initialization strobes shorten the first timeout.

// File: rtl/zdm_pkg.sv
package zdm_pkg;

   // Source selection code for one output (route field, two bits per output)
   typedef enum logic [1:0] {
      SRC_OFF   = 2'b00,
      SRC_RIGHT = 2'b01,
      SRC_LEFT  = 2'b10,
      SRC_MEAN  = 2'b11
   } zdm_src_e;

   // Input channel index used by the zero detectors
   localparam int unsigned CH_LEFT  = 0;
   localparam int unsigned CH_RIGHT = 1;
   localparam int unsigned N_CH     = 2;

   function automatic logic src_uses_left(zdm_src_e s);
      return (s == SRC_LEFT) || (s == SRC_MEAN);
   endfunction

   function automatic logic src_uses_right(zdm_src_e s);
      return (s == SRC_RIGHT) || (s == SRC_MEAN);
   endfunction

endpackage

// File: rtl/zdm_route_qual.sv
module zdm_route_qual
   import zdm_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned GAIN_W = 8
) (
   input  logic [DATA_W-1:0] left_i,
   input  logic [DATA_W-1:0] right_i,
   input  logic [3:0]        route_i,
   input  logic [GAIN_W-1:0] gain_l_i,
   input  logic [GAIN_W-1:0] gain_r_i,
   output logic              data_qual_o,
   output logic              gain_qual_o,
   output logic              qual_o
);

   localparam int unsigned N_OUT = 2;

   logic [N_CH-1:0][DATA_W-1:0] smp;
   logic [N_CH-1:0]             in_zero;
   logic [N_OUT-1:0]            use_l;
   logic [N_OUT-1:0]            use_r;
   logic [N_OUT-1:0]            out_off;

   assign smp[CH_LEFT]  = left_i;
   assign smp[CH_RIGHT] = right_i;

   // one zero detector per input channel
   for (genvar c = 0; c < N_CH; c++) begin : g_zero
      assign in_zero[c] = (smp[c] == '0);
   end

   // per-output routing decode; output 0 = right output (bits 1:0), 1 = left output
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      zdm_src_e sel;
      assign sel        = zdm_src_e'(route_i[2*o+1:2*o]);
      assign use_l[o]   = src_uses_left(sel);
      assign use_r[o]   = src_uses_right(sel);
      assign out_off[o] = (sel == SRC_OFF);
   end

   logic left_used, right_used, both_zero, routed_zero, all_off;

   always_comb begin
      left_used   = |use_l;
      right_used  = |use_r;
      both_zero   = &in_zero;
      routed_zero = (!left_used  || in_zero[CH_LEFT]) &&
                    (!right_used || in_zero[CH_RIGHT]);
      all_off     = &out_off;
      data_qual_o = both_zero || routed_zero || all_off;
      gain_qual_o = (gain_l_i == '0) && (gain_r_i == '0);
      qual_o      = data_qual_o || gain_qual_o;
   end

endmodule

// File: rtl/zdm_init_win.sv
module zdm_init_win #(
   parameter int unsigned INIT_STROBES = 9
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stb_i,
   output logic done_o,
   output logic last_o
);

   localparam int unsigned IW = (INIT_STROBES < 2) ? 1 : $clog2(INIT_STROBES);
   localparam logic [IW-1:0] LAST_IDX = IW'(INIT_STROBES - 1);

   logic [IW-1:0] cnt_q;
   logic          done_q;

   assign last_o = stb_i && !done_q && (cnt_q == LAST_IDX);
   assign done_o = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (stb_i && !done_q) begin
         if (cnt_q == LAST_IDX) begin
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // strobe index never runs past the window length (R1)
   assert_init_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST_IDX);

   // once finished, the window never reopens without reset (R1)
   assert_init_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> done_q);

endmodule

// File: rtl/zdm_sil_timer.sv
module zdm_sil_timer #(
   parameter int unsigned SIL_LOG2 = 14
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stb_i,
   input  logic run_i,
   input  logic init_last_i,
   input  logic qual_i,
   output logic flag_o
);

   localparam int unsigned CNT_W = SIL_LOG2 + 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(1) << SIL_LOG2;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             flag_q;

   always_comb begin
      cnt_nxt = (cnt_q == TERM) ? cnt_q : cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         flag_q <= 1'b1;
      end else if (stb_i) begin
         if (!run_i) begin
            cnt_q  <= '0;
            flag_q <= !init_last_i;
         end else if (qual_i) begin
            cnt_q  <= cnt_nxt;
            flag_q <= (cnt_nxt == TERM);
         end else begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
         end
      end
   end

   assign flag_o = flag_q;

   assert_sat_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= TERM);

   assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && stb_i && qual_i && flag_q) |=> flag_q);

   assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && stb_i && !qual_i) |=> (!flag_q && cnt_q == '0));

   assert_rise_at_term_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && $rose(flag_q)) |-> (cnt_q == TERM));

   assert_quiet_between_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_i |=> $stable(flag_q));

   assert_no_count_in_init_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> (cnt_q == '0));

endmodule

// File: rtl/zdm_mute_flag.sv
module zdm_mute_flag
   import zdm_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned GAIN_W       = 8,
   parameter int unsigned SIL_LOG2     = 14,
   parameter int unsigned INIT_STROBES = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              stb_i,
   input  logic [DATA_W-1:0] left_i,
   input  logic [DATA_W-1:0] right_i,
   input  logic [3:0]        route_i,
   input  logic [GAIN_W-1:0] gain_l_i,
   input  logic [GAIN_W-1:0] gain_r_i,
   output logic              mute_o
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("zdm_mute_flag: DATA_W must be at least 1");
   end
   if (GAIN_W < 1) begin : g_bad_gain_w
      $error("zdm_mute_flag: GAIN_W must be at least 1");
   end
   if (SIL_LOG2 < 1 || SIL_LOG2 > 30) begin : g_bad_sil
      $error("zdm_mute_flag: SIL_LOG2 must lie in 1..30");
   end
   if (INIT_STROBES < 1) begin : g_bad_init
      $error("zdm_mute_flag: INIT_STROBES must be at least 1");
   end

   logic data_qual, gain_qual, qual;
   logic init_done, init_last;

   zdm_route_qual #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W)
   ) u_qual (
      .left_i      (left_i),
      .right_i     (right_i),
      .route_i     (route_i),
      .gain_l_i    (gain_l_i),
      .gain_r_i    (gain_r_i),
      .data_qual_o (data_qual),
      .gain_qual_o (gain_qual),
      .qual_o      (qual)
   );

   zdm_init_win #(
      .INIT_STROBES (INIT_STROBES)
   ) u_init (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (stb_i),
      .done_o (init_done),
      .last_o (init_last)
   );

   zdm_sil_timer #(
      .SIL_LOG2 (SIL_LOG2)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stb_i       (stb_i),
      .run_i       (init_done),
      .init_last_i (init_last),
      .qual_i      (qual),
      .flag_o      (mute_o)
   );

   assert_init_forced_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_done |-> mute_o);

   assert_init_exit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_last |=> !mute_o);

   assert_all_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_i == 4'b0000) |-> data_qual);

   assert_gain_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gain_l_i == '0 && gain_r_i == '0) |-> qual);

   assert_both_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (left_i == '0 && right_i == '0) |-> data_qual);

endmodule

// File: tb/tb_zdm_mute_flag.sv
module tb_zdm_mute_flag;

   localparam int unsigned DW    = 16;
   localparam int unsigned GW    = 8;
   localparam int unsigned SL2   = 5;
   localparam int unsigned INITN = 9;
   localparam int unsigned LIMIT = 1 << SL2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stb = 1'b0;
   logic [DW-1:0] left_s = '0;
   logic [DW-1:0] right_s = '0;
   logic [3:0]    route = 4'b1001;
   logic [GW-1:0] gl = 8'hFF;
   logic [GW-1:0] gr = 8'hFF;
   logic          mute;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   zdm_mute_flag #(
      .DATA_W (DW), .GAIN_W (GW), .SIL_LOG2 (SL2), .INIT_STROBES (INITN)
   ) dut (
      .clk_i (clk), .rst_ni (rst_n), .stb_i (stb),
      .left_i (left_s), .right_i (right_s), .route_i (route),
      .gain_l_i (gl), .gain_r_i (gr), .mute_o (mute)
   );

   // scoreboard queues
   bit    q_exp[$];
   string q_tag[$];

   // reference model state, written from the requirements
   int m_init = 0;
   bit m_done = 1'b0;
   int m_sil  = 0;

   task automatic check(input bit act, input bit exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: mute_o=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic bit model_qual(input logic [DW-1:0] l, input logic [DW-1:0] r,
                                     input logic [3:0] m, input logic [GW-1:0] a,
                                     input logic [GW-1:0] b);
      bit use_l, use_r;
      use_l = (m[3:2] == 2'b10) || (m[3:2] == 2'b11) || (m[1:0] == 2'b10) || (m[1:0] == 2'b11);
      use_r = (m[3:2] == 2'b01) || (m[3:2] == 2'b11) || (m[1:0] == 2'b01) || (m[1:0] == 2'b11);
      return (l == 0 && r == 0) || (m == 4'b0000) ||
             ((!use_l || l == 0) && (!use_r || r == 0)) || (a == 0 && b == 0);
   endfunction

   function automatic bit model_step(input bit q);
      if (!m_done) begin
         m_init++;
         if (m_init == INITN) begin
            m_done = 1'b1;
            return 1'b0;
         end
         return 1'b1;
      end
      if (q) begin
         if (m_sil < LIMIT) m_sil++;
         return (m_sil == LIMIT);
      end
      m_sil = 0;
      return 1'b0;
   endfunction

   // driver: one strobe, then one idle cycle (called at a negedge)
   task automatic strobe(input logic [DW-1:0] l, input logic [DW-1:0] r,
                         input logic [3:0] m, input logic [GW-1:0] a,
                         input logic [GW-1:0] b, input string tag);
      left_s = l; right_s = r; route = m; gl = a; gr = b;
      stb = 1'b1;
      q_exp.push_back(model_step(model_qual(l, r, m, a, b)));
      q_tag.push_back(tag);
      @(negedge clk);
      stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_n(input int n, input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input logic [3:0] m, input logic [GW-1:0] a,
                        input logic [GW-1:0] b, input string tag);
      for (int i = 0; i < n; i++) strobe(l, r, m, a, b, tag);
   endtask

   // monitor: pops one expectation per strobe seen at the previous edge
   logic stb_q = 1'b0;
   always @(posedge clk) stb_q <= stb;

   always @(negedge clk) begin
      if (stb_q && q_exp.size() > 0) begin
         check(mute, q_exp.pop_front(), q_tag.pop_front());
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
   end

   initial begin
      // R1: flag high during reset
      repeat (4) @(negedge clk);
      check(mute, 1'b1, "R1 reset value");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: init window with loud stereo data; drops after 9th strobe
      run_n(INITN, 16'h1234, 16'h0F00, 4'b1001, 8'hFF, 8'hFF, "R1 init window");

      // R3 / R7: both zero, exact terminal count
      run_n(LIMIT, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R3 R7 both zero timeout");
      // R9: well beyond twice the terminal count
      run_n(2 * LIMIT + 5, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R9 saturation");

      // R10: change inputs between strobes, flag unchanged
      left_s = 16'h7FFF; right_s = 16'h8000; gl = 8'h10;
      repeat (3) @(negedge clk);
      check(mute, 1'b1, "R10 idle input change");

      // R8: loud sample drops flag, run restarts
      strobe(16'h0001, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R8 drop on loud sample");
      run_n(LIMIT - 1, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R8 partial run");
      strobe(16'h0000, 16'hFFFF, 4'b1001, 8'hFF, 8'hFF, "R8 second break");
      run_n(LIMIT, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R8 R7 restarted run");

      // R4: both outputs take left; right input loud but unused
      run_n(LIMIT, 16'h0000, 16'h4444, 4'b1010, 8'hFF, 8'hFF, "R4 unused channel loud");
      strobe(16'h0100, 16'h4444, 4'b1010, 8'hFF, 8'hFF, "R4 used channel loud");

      // R2: mean on both outputs, right loud -> never qualifies
      run_n(LIMIT + 2, 16'h0000, 16'h0002, 4'b1111, 8'hFF, 8'hFF, "R2 mean uses right");
      // R2: left silenced, right takes mean; left loud -> no qualify
      run_n(4, 16'h0200, 16'h0000, 4'b0011, 8'hFF, 8'hFF, "R2 mean uses left");
      // R2: both outputs take right, left loud unused -> qualifies
      run_n(LIMIT, 16'h0300, 16'h0000, 4'b0101, 8'hFF, 8'hFF, "R2 R4 both take right");
      strobe(16'h0300, 16'h0001, 4'b0101, 8'hFF, 8'hFF, "R2 right loud");

      // R5: both outputs silenced, loud data
      run_n(LIMIT, 16'h5555, 16'hAAAA, 4'b0000, 8'hFF, 8'hFF, "R5 all outputs off");
      strobe(16'h5555, 16'hAAAA, 4'b1000, 8'hFF, 8'hFF, "R5 one output on");

      // R6: one gain zero does not qualify, both do
      run_n(LIMIT + 1, 16'h5555, 16'hAAAA, 4'b1001, 8'h00, 8'h05, "R6 one gain zero");
      run_n(LIMIT, 16'h5555, 16'hAAAA, 4'b1001, 8'h00, 8'h00, "R6 both gains zero");
      strobe(16'h5555, 16'hAAAA, 4'b1001, 8'h01, 8'h00, "R6 gain rises");

      // R1 / R11: reset mid-run, silent input all through the window
      rst_n = 1'b0;
      #1;
      check(mute, 1'b1, "R1 async reset");
      m_init = 0; m_done = 1'b0; m_sil = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_n(INITN, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R1 R11 silent init");
      run_n(LIMIT, 16'h0000, 16'h0000, 4'b1001, 8'hFF, 8'hFF, "R11 R7 first timeout");

      repeat (3) @(negedge clk);
      if (q_exp.size() != 0) begin
         checks++;
         failures++;
         $display("FAIL scoreboard: pending=%0d expected=0", q_exp.size());
      end
      summary();
   end

endmodule